// File: doc/BRIEF.md
# Dual-Channel Diagnostic Probe Controller

This block lets a debug engineer watch two internal nodes of a chip at once, in real time, on two pins that otherwise serve as ordinary user I/O. A mode input hands the two probe pins and the two serial select pins, a diagnostic clock and a serial data line, over to their debug function. While the mode input is high, a frame of select bits is shifted in on rising edges of the diagnostic clock. Each probe pin then carries the node its own field picks. While the mode input is low, every shared pin belongs to user logic again.

The frame carries two select fields, each `SELW` bits wide and most significant bit first. The probe A field is sent first and the probe B field follows. A new pair of selections takes effect only when a complete frame has arrived. A partial frame is discarded when the mode input falls. A one-time security input locks the block: from then on nothing can be observed and the shared pins return to user I/O. Only a reset clears the lock.

All inputs are sampled on the system clock `clk`. The diagnostic clock is edge-detected in that domain, so it must run well below half the system clock rate.

Top module: `dbg_probe_ctrl`

## Requirements
- R1: During and after reset both probe outputs are 0, and both stored selections are node 0.
- R2: `probe_pin_en` and `serial_pin_en` are 1 exactly when `mode_in` is 1 and the block is not locked. They follow their inputs in the same cycle.
- R3: While `mode_in` is 1 and the block is unlocked, each rising edge of `dclk_in` shifts in one bit from `sdata_in`. Of a 2*SELW-bit frame, the first SELW bits form the probe A select (MSB first) and the last SELW bits form the probe B select (MSB first).
- R4: Stored selections change only when the 2*SELW-th bit of a frame is shifted in. After fewer bits, the probe outputs still follow the previous selections.
- R5: A falling `mode_in` discards a partial frame. The next frame starts again with the probe A field.
- R6: With mode high and unlocked, `probe_a` shows `node_bus[sel_a]` and `probe_b` shows `node_bus[sel_b]` one clock later. The two channels are independent and update at the same time.
- R7: A select value of `NODES` or above drives that probe output to 0.
- R8: With `mode_in` low, both probe outputs are 0, and `dclk_in` and `sdata_in` have no effect. The stored selections are kept for the next time mode is high.
- R9: Once `secure_in` is seen high, the block stays locked until reset, whatever `secure_in` does afterwards. While locked, both probe outputs are 0 and both pin enables are 0, even with mode high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_bus | input | NODES | Internal nodes available for observation |
| mode_in | input | 1 | 1 selects debug function for the shared pins |
| dclk_in | input | 1 | Diagnostic shift clock, edge-detected |
| sdata_in | input | 1 | Serial select data |
| secure_in | input | 1 | One-time security bit; locks the block |
| probe_a | output | 1 | First probe pin value |
| probe_b | output | 1 | Second probe pin value |
| probe_pin_en | output | 1 | Probe pins carry probe values, not user I/O |
| serial_pin_en | output | 1 | Clock and data pins serve the select path |

## Verification
The bench builds the block with NODES = 12, so SELW is 4 and a frame is 8 bits. Select codes 12 to 15 are then out of range, and both the R7 zeroing and the in-range picks up to node 11 can be reached. An 8-bit frame is short enough to abort mid-way, which exposes frame misalignment if a partial frame is not discarded. The same frame can then be replayed both while locked and while mode is low.

// File: rtl/probe_pkg.sv
package probe_pkg;
  // Width of a select field for n observable nodes (at least one bit).
  function automatic int sel_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  localparam int CHANNELS = 2;
endpackage

// File: rtl/probe_lock.sv
module probe_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic secure_in,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= locked | secure_in;
  end

  // R9: lock never falls outside reset
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R9: a seen security bit always locks
  assert_lock_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    secure_in |=> locked);
endmodule

// File: rtl/probe_shift.sv
module probe_shift #(
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_in,
  input  logic            dclk_in,
  input  logic            sdata_in,
  input  logic            locked,
  output logic [SELW-1:0] sel_a,
  output logic [SELW-1:0] sel_b
);
  localparam int FRAME = 2 * SELW;
  localparam int CNTW  = $clog2(FRAME + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(FRAME - 1);

  logic             dclk_q;
  logic             mode_q;
  logic [FRAME-1:0] sr;
  logic [FRAME-1:0] sr_next;
  logic [CNTW-1:0]  cnt;
  logic             shift_en;
  logic             mode_fall;

  assign shift_en  = mode_in & ~locked & dclk_in & ~dclk_q;
  assign mode_fall = mode_q & ~mode_in;
  assign sr_next   = {sr[FRAME-2:0], sdata_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      mode_q <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
      sel_a  <= '0;
      sel_b  <= '0;
    end else begin
      dclk_q <= dclk_in;
      mode_q <= mode_in;
      if (locked || mode_fall) begin
        cnt <= '0;
      end else if (shift_en) begin
        sr <= sr_next;
        if (cnt == LAST) begin
          cnt   <= '0;
          sel_a <= sr_next[FRAME-1:SELW];
          sel_b <= sr_next[SELW-1:0];
        end else begin
          cnt <= cnt + CNTW'(1);
        end
      end
    end
  end

  // R4: frame position never passes the frame length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNTW'(FRAME));
  // R8: selections only change after a cycle with mode high
  assert_sel_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed({sel_a, sel_b}) |-> $past(mode_in));
  // R9: selections frozen while locked
  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({sel_a, sel_b}));
  // R5: a falling mode restarts the frame
  assert_abort_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fall |=> cnt == '0);
endmodule

// File: rtl/probe_mux.sv
module probe_mux #(
  parameter int NODES = 12,
  parameter int SELW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] node_bus,
  input  logic [SELW-1:0]  sel,
  input  logic             active,
  output logic             probe
);
  localparam int SPAN = 1 << SELW;

  logic [SPAN-1:0] padded;
  assign padded = SPAN'(node_bus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      probe <= 1'b0;
    else if (active) probe <= padded[sel];
    else             probe <= 1'b0;
  end

  // R8/R9: nothing shown while inactive
  assert_quiet_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !probe);
  // R7: out-of-range select reads as 0
  assert_range_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel) >= NODES) |=> !probe);
endmodule

// File: rtl/dbg_probe_ctrl.sv
module dbg_probe_ctrl #(
  parameter int NODES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] node_bus,
  input  logic             mode_in,
  input  logic             dclk_in,
  input  logic             sdata_in,
  input  logic             secure_in,
  output logic             probe_a,
  output logic             probe_b,
  output logic             probe_pin_en,
  output logic             serial_pin_en
);
  import probe_pkg::*;

  localparam int SELW = sel_bits(NODES);

  logic            locked;
  logic            active;
  logic [SELW-1:0] sel_a;
  logic [SELW-1:0] sel_b;
  logic [SELW-1:0] chan_sel [CHANNELS];
  logic            chan_out [CHANNELS];

  assign active        = mode_in & ~locked;
  assign probe_pin_en  = active;
  assign serial_pin_en = active;

  probe_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .secure_in (secure_in),
    .locked    (locked)
  );

  probe_shift #(.SELW(SELW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (mode_in),
    .dclk_in  (dclk_in),
    .sdata_in (sdata_in),
    .locked   (locked),
    .sel_a    (sel_a),
    .sel_b    (sel_b)
  );

  assign chan_sel[0] = sel_a;
  assign chan_sel[1] = sel_b;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    probe_mux #(.NODES(NODES), .SELW(SELW)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .node_bus (node_bus),
      .sel      (chan_sel[c]),
      .active   (active),
      .probe    (chan_out[c])
    );
  end

  assign probe_a = chan_out[0];
  assign probe_b = chan_out[1];

  // R2: debug pin function never granted with mode low
  assert_pin_en_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_pin_en |-> mode_in);
  // R9: locked block releases the pins
  assert_pin_en_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !probe_pin_en && !serial_pin_en);
endmodule

// File: tb/tb_dbg_probe_ctrl.sv
module tb_dbg_probe_ctrl;
  localparam int NODES = 12;

  logic clk = 1'b0;
  logic rst_n, mode_in, dclk_in, sdata_in, secure_in;
  logic [NODES-1:0] node_bus;
  logic probe_a, probe_b, probe_pin_en, serial_pin_en;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_probe_ctrl #(.NODES(NODES)) dut (
    .clk(clk), .rst_n(rst_n), .node_bus(node_bus), .mode_in(mode_in),
    .dclk_in(dclk_in), .sdata_in(sdata_in), .secure_in(secure_in),
    .probe_a(probe_a), .probe_b(probe_b),
    .probe_pin_en(probe_pin_en), .serial_pin_en(serial_pin_en)
  );

  // {sel_a, sel_b, nodes, exp_a, exp_b}
  localparam logic [21:0] VEC [6] = '{
    {4'd0,  4'd11, 12'h801, 1'b1, 1'b1},
    {4'd3,  4'd3,  12'h008, 1'b1, 1'b1},
    {4'd5,  4'd6,  12'h020, 1'b1, 1'b0},
    {4'd13, 4'd2,  12'hFFF, 1'b0, 1'b1},
    {4'd7,  4'd15, 12'hF7F, 1'b0, 1'b0},
    {4'd10, 4'd9,  12'h400, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    sdata_in = b;
    dclk_in  = 1'b1;
    @(negedge clk);
    dclk_in  = 1'b0;
  endtask

  task automatic load_frame(input logic [3:0] a, input logic [3:0] b);
    for (int i = 3; i >= 0; i--) shift_bit(a[i]);
    for (int i = 3; i >= 0; i--) shift_bit(b[i]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_in = 1'b0; dclk_in = 1'b0; sdata_in = 1'b0;
    secure_in = 1'b0; node_bus = '1;
    repeat (3) @(negedge clk);
    check("R1 probe_a in reset", probe_a, 1'b0);
    check("R1 probe_b in reset", probe_b, 1'b0);
    rst_n = 1'b1;
    settle();
    check("R8 probe_a mode low", probe_a, 1'b0);
    check("R2 probe_pin_en mode low", probe_pin_en, 1'b0);

    @(negedge clk);
    mode_in = 1'b1;
    node_bus = 12'h001;
    #1;
    check("R2 probe_pin_en mode high", probe_pin_en, 1'b1);
    check("R2 serial_pin_en mode high", serial_pin_en, 1'b1);
    settle();
    check("R1 reset select A is node 0", probe_a, 1'b1);
    check("R1 reset select B is node 0", probe_b, 1'b1);

    // R3 R6 R7: table walk
    for (int v = 0; v < 6; v++) begin
      logic [3:0] sa, sb;
      sa = VEC[v][21:18];
      sb = VEC[v][17:14];
      load_frame(sa, sb);
      node_bus = VEC[v][13:2];
      settle();
      check(sa >= 4'd12 ? "R7 probe_a" : "R6 probe_a", probe_a, VEC[v][1]);
      check(sb >= 4'd12 ? "R7 probe_b" : "R3 probe_b", probe_b, VEC[v][0]);
      node_bus = ~VEC[v][13:2];
      settle();
      check(sa >= 4'd12 ? "R7 probe_a inv" : "R6 probe_a inv", probe_a,
            sa >= 4'd12 ? 1'b0 : ~VEC[v][1]);
      check(sb >= 4'd12 ? "R7 probe_b inv" : "R6 probe_b inv", probe_b,
            sb >= 4'd12 ? 1'b0 : ~VEC[v][0]);
    end

    // R4: partial frame leaves selections alone
    load_frame(4'd3, 4'd3);
    node_bus = 12'h008;
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    settle();
    check("R4 probe_a after partial", probe_a, 1'b1);
    check("R4 probe_b after partial", probe_b, 1'b1);

    // R5: mode fall discards partial frame
    mode_in = 1'b0;
    settle();
    mode_in = 1'b1;
    load_frame(4'd1, 4'd2);
    node_bus = 12'h002;
    settle();
    check("R5 probe_a realigned", probe_a, 1'b1);
    check("R5 probe_b realigned", probe_b, 1'b0);

    // R8: mode low silences probes and ignores shifting
    mode_in = 1'b0;
    node_bus = 12'h006;
    settle();
    check("R8 probe_a silent", probe_a, 1'b0);
    check("R8 probe_b silent", probe_b, 1'b0);
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    mode_in = 1'b1;
    settle();
    check("R8 select A kept", probe_a, 1'b1);
    check("R8 select B kept", probe_b, 1'b1);

    // R9: security lock
    @(negedge clk);
    secure_in = 1'b1;
    settle();
    check("R9 probe_a locked", probe_a, 1'b0);
    check("R9 probe_b locked", probe_b, 1'b0);
    check("R9 probe_pin_en locked", probe_pin_en, 1'b0);
    secure_in = 1'b0;
    load_frame(4'd1, 4'd2);
    settle();
    check("R9 stays locked probe_a", probe_a, 1'b0);
    check("R9 stays locked serial_pin_en", serial_pin_en, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    node_bus = 12'h001;
    settle();
    check("R9 reset unlocks", probe_pin_en, 1'b1);
    check("R1 post-reset select A", probe_a, 1'b1);
    check("R1 post-reset select B", probe_b, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule